// File: doc/BRIEF.md
# Banked Memory Window Address Expander

This unit lets an 8-bit processor with a 16-bit address map reach a larger physical memory through programmable windows. Each window has a base (a 4 KB boundary chosen by the upper nibble of the CPU address), a size code, and a bank register. While a CPU access falls inside an enabled window, that window's bank value drives the expansion address lines `xa`. When no window covers the access, the lines stay at zero. When windows overlap, the lower-numbered window wins.

The unit also picks which memory answers each access. The on-chip register block, RAM and EEPROM always answer at their CPU address, whatever bank is selected. On-chip ROM answers inside a window only when the low three bits of the selected bank are all zero; otherwise the access goes to external memory. Software sets up the windows through a small register port with combinational read-back.

The outputs are registered and follow a two-state access tracker. The tracker enters `ST_ACCESS` on any clock edge where a read or write strobe is high, and enters `ST_IDLE` on any edge where both strobes are low. In `ST_ACCESS` the outputs show the decode of the address sampled at that edge. In `ST_IDLE` all outputs are zero.

Top module: `bank_window_expander`

## Requirements
- R1: After reset, every configuration register reads zero, both windows are disabled, and an access then yields `xa` = 0 with the region chosen by the fixed map alone.
- R2: Configuration addresses are as follows: 0 is the window-1 bank, 1 is the window-2 bank, 2 is the window-1 setup and 3 is the window-2 setup. A setup register holds the base nibble in bits [7:4] and the size code in bits [1:0]. Bits that are not implemented read back as zero: bit 7 of the window-1 bank, bit 0 of the window-2 bank, and bits [3:2] of each setup register.
- R3: A window covers the CPU addresses from base×4096 up to, but not including, base×4096 + span. The span is 8 KB for size code 1, 16 KB for code 2 and 32 KB for code 3. Code 0 disables the window. Coverage stops at the top of the 64 KB map.
- R4: During an access inside a window, `xa` equals that window's bank register. Outside every enabled window, `xa` is zero.
- R5: Where both windows cover an address, window 1 supplies `xa`, and window 2 cannot be reached there.
- R6: The register block (0x0000–0x007F), RAM (0x0080–0x047F) and EEPROM (0x0D80–0x0FFF) are selected at their addresses in every bank and inside any window. The priority among them is registers, then RAM, then EEPROM.
- R7: ROM (0x8000–0xFFFF) is selected outside any window. Inside a window it is selected only when bits [2:0] of the selected bank are 000; otherwise the access goes to external memory.
- R8: `region_sel` is one-hot during an access. Bit 0 selects registers, bit 1 RAM, bit 2 EEPROM, bit 3 ROM and bit 4 external memory. Any address not claimed by an on-chip region selects external memory.
- R9: The outputs reflect the address sampled at the clock edge where a read or write strobe was high, and they are valid from that edge until the next one. After an edge where no strobe was high, `xa` and `region_sel` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W (16) | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register address (shared by write and read) |
| cfg_wdata | input | DATA_W (8) | Configuration write data |
| cfg_rdata | output | DATA_W (8) | Configuration read-back, combinational |
| xa | output | DATA_W (8) | Expansion address lines (bank value) |
| region_sel | output | 5 | One-hot region select |

## Verification
The bench builds the block with its default parameters: a 16-bit map, two windows, 8-bit bank registers and the fixed region map given above. With these defaults, every base nibble and size code is reachable, so windows can cover the on-chip regions, overlap each other and run past the top of the map. Seeded random bank values land on both sides of the ROM bank-zero test. Directed cases pin the window edges, the clipping at the top of the map and the unimplemented bits.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } acc_state_e;

    typedef enum logic [2:0] {
        RG_REG = 3'd0,
        RG_RAM = 3'd1,
        RG_EEP = 3'd2,
        RG_ROM = 3'd3,
        RG_EXT = 3'd4
    } region_e;

    localparam int NUM_REGIONS = 5;
    localparam int BASE_NIB_W  = 4;
    localparam int SIZE_CODE_W = 2;

endpackage

// File: rtl/bwx_regs.sv
module bwx_regs
    import bwx_pkg::*;
#(
    parameter  int NUM_WIN = 2,
    parameter  int DATA_W  = 8,
    localparam int AW      = $clog2(2 * NUM_WIN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic [DATA_W-1:0]      bank_q [NUM_WIN],
    output logic [BASE_NIB_W-1:0]  base_q [NUM_WIN],
    output logic [SIZE_CODE_W-1:0] size_q [NUM_WIN]
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [DATA_W-1:0] MASK =
            (g == 0) ? {1'b0, {(DATA_W-1){1'b1}}} :
            (g == 1) ? {{(DATA_W-1){1'b1}}, 1'b0} : {DATA_W{1'b1}};

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
                base_q[g] <= '0;
                size_q[g] <= '0;
            end else begin
                if (we && addr == AW'(g))
                    bank_q[g] <= wdata & MASK;
                if (we && addr == AW'(NUM_WIN + g)) begin
                    base_q[g] <= wdata[7:4];
                    size_q[g] <= wdata[1:0];
                end
            end
        end

        // R2: read-back of a bank register never shows unimplemented bits
        a_r2_unimpl_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == AW'(g)) |-> ((rdata & ~MASK) == '0));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (addr == AW'(i))
                rdata = bank_q[i];
            if (addr == AW'(NUM_WIN + i))
                rdata = DATA_W'({base_q[i], 2'b00, size_q[i]});
        end
    end

    // R2: setup registers read back with bits [3:2] clear
    a_r2_setup_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= AW'(NUM_WIN)) |-> (rdata[3:2] == 2'b00));

endmodule

// File: rtl/bwx_window.sv
module bwx_window
    import bwx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [BASE_NIB_W-1:0]  base,
    input  logic [SIZE_CODE_W-1:0] size,
    output logic                   hit
);

    localparam logic [ADDR_W:0] UNIT = (ADDR_W+1)'(1) << (ADDR_W - 3);

    logic [ADDR_W:0] lo;
    logic [ADDR_W:0] span;
    logic [ADDR_W:0] a_ext;

    always_comb begin
        lo    = {1'b0, base, {(ADDR_W-BASE_NIB_W){1'b0}}};
        a_ext = {1'b0, addr};
        span  = (size == '0) ? '0 : (UNIT << (size - 2'd1));
        hit   = (size != '0) && (a_ext >= lo) && (a_ext < lo + span);
    end

endmodule

// File: rtl/bwx_decode.sv
module bwx_decode
    import bwx_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int unsigned REG_BASE = 32'h0000,
    parameter int unsigned REG_SIZE = 32'h0080,
    parameter int unsigned RAM_BASE = 32'h0080,
    parameter int unsigned RAM_SIZE = 32'h0400,
    parameter int unsigned EEP_BASE = 32'h0D80,
    parameter int unsigned EEP_SIZE = 32'h0280,
    parameter int unsigned ROM_BASE = 32'h8000,
    parameter int unsigned ROM_SIZE = 32'h8000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              in_window,
    input  logic              bank_is_zero,
    output region_e           region
);

    logic [31:0] a32;
    logic in_reg, in_ram, in_eep, in_rom;

    always_comb begin
        a32    = 32'(addr);
        in_reg = (a32 >= REG_BASE) && (a32 < REG_BASE + REG_SIZE);
        in_ram = (a32 >= RAM_BASE) && (a32 < RAM_BASE + RAM_SIZE);
        in_eep = (a32 >= EEP_BASE) && (a32 < EEP_BASE + EEP_SIZE);
        in_rom = (a32 >= ROM_BASE) && (a32 < ROM_BASE + ROM_SIZE);

        if (in_reg)
            region = RG_REG;
        else if (in_ram)
            region = RG_RAM;
        else if (in_eep)
            region = RG_EEP;
        else if (in_rom && (!in_window || bank_is_zero))
            region = RG_ROM;
        else
            region = RG_EXT;
    end

endmodule

// File: rtl/bank_window_expander.sv
module bank_window_expander
    import bwx_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int NUM_WIN       = 2,
    parameter int ROM_BANK_BITS = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              cpu_addr,
    input  logic                           cpu_rd,
    input  logic                           cpu_wr,
    input  logic                           cfg_we,
    input  logic [$clog2(2*NUM_WIN)-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]              cfg_wdata,
    output logic [DATA_W-1:0]              cfg_rdata,
    output logic [DATA_W-1:0]              xa,
    output logic [NUM_REGIONS-1:0]         region_sel
);

    logic [DATA_W-1:0]      bank_q [NUM_WIN];
    logic [BASE_NIB_W-1:0]  base_q [NUM_WIN];
    logic [SIZE_CODE_W-1:0] size_q [NUM_WIN];
    logic [NUM_WIN-1:0]     hit;

    logic [DATA_W-1:0] pick_bank;
    logic              any_hit;
    logic              bank_zero;
    region_e           dec_region;

    acc_state_e        state_q, state_d;
    logic [DATA_W-1:0] xa_lat;
    region_e           region_lat;
    logic              strobe;

    bwx_regs #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .bank_q (bank_q),
        .base_q (base_q),
        .size_q (size_q)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        bwx_window #(.ADDR_W(ADDR_W)) u_win (
            .addr (cpu_addr),
            .base (base_q[g]),
            .size (size_q[g]),
            .hit  (hit[g])
        );
    end

    // lowest-numbered window that hits supplies the bank
    always_comb begin
        pick_bank = '0;
        any_hit   = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                pick_bank = bank_q[i];
                any_hit   = 1'b1;
            end
        end
        bank_zero = (pick_bank[ROM_BANK_BITS-1:0] == '0);
    end

    bwx_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr         (cpu_addr),
        .in_window    (any_hit),
        .bank_is_zero (bank_zero),
        .region       (dec_region)
    );

    assign strobe = cpu_rd | cpu_wr;

    // access tracker: state register
    always_comb state_d = strobe ? ST_ACCESS : ST_IDLE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            xa_lat     <= '0;
            region_lat <= RG_EXT;
        end else begin
            state_q    <= state_d;
            xa_lat     <= pick_bank;
            region_lat <= dec_region;
        end
    end

    // access tracker: outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                xa         = '0;
                region_sel = '0;
            end
            ST_ACCESS: begin
                xa         = xa_lat;
                region_sel = NUM_REGIONS'(1) << region_lat;
            end
            default: begin
                xa         = '0;
                region_sel = '0;
            end
        endcase
    end

    // R8: a strobed access yields exactly one region
    a_r8_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> ($countones(region_sel) == 1));

    // R9: no strobe, quiet outputs next cycle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (region_sel == '0 && xa == '0));

    // R4: outside every window the expansion lines are zero
    a_r4_no_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && hit == '0) |=> (xa == '0));

    // R5: window 1 supplies the bank wherever it hits
    a_r5_first_window_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && hit[0]) |=> (xa == $past(bank_q[0])));

    // R7: ROM inside a window only for bank low bits zero
    a_r7_rom_bank_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_region == RG_ROM) |-> (!any_hit || pick_bank[ROM_BANK_BITS-1:0] == '0));

endmodule

// File: tb/tb_bank_window_expander.sv
`timescale 1ns/1ps
module tb_bank_window_expander;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [7:0] xa;
    logic [4:0] region_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // shadow configuration kept by the bench
    logic [7:0] sh_bank [2];
    logic [3:0] sh_base [2];
    logic [1:0] sh_size [2];

    always #2 clk = ~clk;

    bank_window_expander dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xa(xa),
        .region_sel(region_sel)
    );

    function automatic bit m_hit(int w, int a);
        int lo, sp;
        if (sh_size[w] == 0) return 0;
        lo = int'(sh_base[w]) * 4096;
        sp = 8192 << (int'(sh_size[w]) - 1);
        return (a >= lo) && (a < lo + sp);
    endfunction

    function automatic logic [7:0] m_xa(int a);
        if (m_hit(0, a)) return sh_bank[0];
        if (m_hit(1, a)) return sh_bank[1];
        return 8'h00;
    endfunction

    function automatic logic [4:0] m_sel(int a);
        bit inw;
        inw = m_hit(0, a) || m_hit(1, a);
        if (a < 'h80) return 5'b00001;
        if (a < 'h480) return 5'b00010;
        if (a >= 'hD80 && a < 'h1000) return 5'b00100;
        if (a >= 'h8000 && (!inw || m_xa(a)[2:0] == 3'b000)) return 5'b01000;
        return 5'b10000;
    endfunction

    task automatic cfg_write(int ad, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(ad); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (ad)
            0: sh_bank[0] = d & 8'h7F;
            1: sh_bank[1] = d & 8'hFE;
            2: begin sh_base[0] = d[7:4]; sh_size[0] = d[1:0]; end
            default: begin sh_base[1] = d[7:4]; sh_size[1] = d[1:0]; end
        endcase
    endtask

    task automatic check_read(int ad, logic [7:0] exp, string req);
        @(negedge clk);
        cfg_addr = 2'(ad);
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s readback addr %0d: got %02h expected %02h", req, ad, cfg_rdata, exp);
        end
    endtask

    task automatic access(int a, bit use_wr, string req);
        logic [7:0] ex;
        logic [4:0] es;
        ex = m_xa(a);
        es = m_sel(a);
        @(negedge clk);
        cpu_addr = 16'(a);
        cpu_rd = !use_wr; cpu_wr = use_wr;
        @(posedge clk);
        #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        checks++;
        if (xa !== ex || region_sel !== es) begin
            errors++;
            $display("FAIL %s addr %04h: got xa=%02h sel=%05b expected xa=%02h sel=%05b",
                     req, a, xa, region_sel, ex, es);
        end
    endtask

    task automatic idle_check(string req);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        cpu_addr = 16'h9000;
        @(posedge clk);
        #1;
        checks++;
        if (xa !== 8'h00 || region_sel !== 5'b0) begin
            errors++;
            $display("FAIL %s idle: got xa=%02h sel=%05b expected xa=00 sel=00000", req, xa, region_sel);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        for (int w = 0; w < 2; w++) begin
            sh_bank[w] = '0; sh_base[w] = '0; sh_size[w] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 4; i++) check_read(i, 8'h00, "R1");
        idle_check("R1");
        access('h0010, 0, "R1");
        access('h9000, 0, "R1");
        access('h2000, 0, "R1");

        // R2: unimplemented bits
        for (int i = 0; i < 4; i++) cfg_write(i, 8'hFF);
        check_read(0, 8'h7F, "R2");
        check_read(1, 8'hFE, "R2");
        check_read(2, 8'hF3, "R2");
        check_read(3, 8'hF3, "R2");

        // R7: ROM gated by bank low bits
        cfg_write(3, 8'h00);
        cfg_write(2, 8'h83);
        cfg_write(0, 8'h05);
        access('h9000, 0, "R7");
        cfg_write(0, 8'h08);
        access('h9000, 1, "R7");
        cfg_write(2, 8'h00);
        access('h9000, 0, "R7");

        // R6: on-chip regions visible inside a window
        cfg_write(2, 8'h01);
        cfg_write(0, 8'h03);
        access('h0010, 0, "R6");
        access('h0100, 0, "R6");
        access('h0E00, 0, "R6");
        access('h1500, 0, "R6");

        // R5: window 1 over window 2
        cfg_write(0, 8'h11);
        cfg_write(1, 8'h22);
        cfg_write(2, 8'h22);
        cfg_write(3, 8'h03);
        access('h3000, 0, "R5");
        access('h1000, 0, "R5");
        access('h6000, 0, "R5");

        // R3/R4: edges and clipping at top of map
        cfg_write(2, 8'h00);
        cfg_write(3, 8'hE3);
        cfg_write(1, 8'h40);
        access('hDFFF, 0, "R3");
        access('hE000, 0, "R3");
        access('hFFFF, 0, "R3");
        cfg_write(3, 8'h41);
        access('h3FFF, 0, "R4");
        access('h4000, 0, "R4");
        access('h5FFF, 0, "R4");
        access('h6000, 0, "R4");

        // R9: strobe low gives quiet outputs
        idle_check("R9");
        access('h8000, 1, "R9");
        idle_check("R9");

        // random configurations and addresses (R8 one-hot and map)
        for (int t = 0; t < 300; t++) begin
            cfg_write(0, 8'($urandom));
            cfg_write(1, 8'($urandom));
            cfg_write(2, 8'($urandom));
            cfg_write(3, 8'($urandom));
            for (int k = 0; k < 12; k++) begin
                int a;
                a = int'($urandom) & 'hFFFF;
                if (k < 3) a = int'(sh_base[k % 2]) * 4096 + (int'($urandom) & 'h1FFF);
                if (a > 'hFFFF) a = 'hFFFF;
                access(a, k[0], "R8");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule